// File: doc/BRIEF.md
# Secure Context Save Sequencer

This block runs the ordered dump of a crypto engine's volatile state into a memory buffer before the chip enters a low-power state. A single start pulse launches a fixed chain of phases. Each phase issues one or more transfer commands to an engine and DMA port. Every command names an operation, a source, a key slot, a word quad, a destination address and a byte length. The sequencer waits for the engine to finish each command before it issues the next. It stops at once if the engine reports an error.

The buffer is 1072 bytes with a fixed layout. The first 16 bytes hold random data, which is encrypted in place. The next 16 bytes hold sticky configuration bits. Then come 512 bytes of key material, two 16-byte quads for each of the 16 slots. These are followed by 256 bytes of original IVs and 256 bytes of updated IVs. The last 16 bytes hold a counting-byte pattern, which is encrypted in place so that the restore path can check the key. Near the end of the chain, the buffer base is written to a scratch register. The final command commits the root key with a length of zero.

The AES core, the random source and the DMA datapath are not part of this block. They sit behind the command and response handshake.

Top module: `ctx_save_seq`

## Requirements
- R1: While reset is held and after it is released, busyOut, cmdValid, doneOut and scratchWe are all 0.
- R2: A startIn pulse while idle samples baseAddrIn and raises busyOut in the next cycle. In that same cycle the first command is presented. baseAddrIn has no effect after the sample is taken.
- R3: Command order is fixed: root-key generation (cmdOp 0, address base), random fill (cmdOp 1, base+0), in-place encryption of the random data (cmdOp 3, source 2, base+0), sticky-bit save (source 0, base+16), key table, original IVs, updated IVs, pattern load, pattern encryption, then root-key save. Every length is 16 except the last.
- R4: For save commands (cmdOp 3), cmdWord carries the source in bits 31:30, the slot index in bits 11:8 and the quad code in bits 1:0. Source codes: 0 sticky bits, 1 key table, 2 memory, 3 root key. Quad codes: 0 key words 0-3, 1 key words 4-7, 2 original IV, 3 updated IV. For cmdOp 0, 1 and 2, cmdWord is 0.
- R5: The key-table phase issues 32 save commands with source 1. It runs slot 0 to 15, and within each slot quad 0 then quad 1. The address of transfer k is base+32+16k, with length 16.
- R6: The original-IV phase issues 16 commands, quad 2, slot i, at base+544+16i. The updated-IV phase then issues 16 commands, quad 3, at base+800+16i. All use source 1 and length 16.
- R7: A pattern load (cmdOp 2) at base+1056, length 16, carries cmdData with byte i (bits 8i+7:8i) equal to i for i = 0..15. It is followed by an in-place encryption: cmdOp 3, source 2, at base+1056.
- R8: One cycle after the pattern encryption completes, scratchWe pulses for exactly one cycle with scratchData equal to the sampled base. This happens before the root-key save is issued.
- R9: The last command is a save with source 3, slot 0, quad 0, address base and length 0.
- R10: cmdValid and all command fields hold steady until cmdReady. cmdValid drops in the cycle after acceptance. No new command appears until rspDone is received.
- R11: A rspDone with rspErr set ends the sequence. The next cycle gives doneOut with errOut 1. After that, no command and no scratch write follows.
- R12: One cycle after the final rspDone, doneOut pulses for one cycle with errOut 0, and busyOut is 0 in the following cycle. errOut holds its value until the next accepted start.
- R13: A startIn pulse while busyOut is 1 is ignored. The sequence and its addresses continue from the first sampled base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start pulse |
| baseAddrIn | input | 32 | Buffer base address, sampled at start |
| busyOut | output | 1 | Sequence in progress |
| doneOut | output | 1 | One-cycle end-of-sequence pulse |
| errOut | output | 1 | Status of the last sequence: 0 ok, 1 error |
| cmdValid | output | 1 | Command presented |
| cmdReady | input | 1 | Engine accepts the command |
| cmdOp | output | 2 | 0 key generate, 1 random fill, 2 pattern load, 3 save or encrypt |
| cmdWord | output | 32 | Source, slot and quad fields |
| cmdAddr | output | 32 | Destination byte address |
| cmdLen | output | 16 | Transfer length in bytes |
| cmdData | output | 128 | Pattern bytes for the pattern load |
| rspDone | input | 1 | Engine finished the outstanding command |
| rspErr | input | 1 | Error flag, qualified by rspDone |
| scratchWe | output | 1 | Scratch register write strobe |
| scratchData | output | 32 | Value to write to the scratch register |

## Verification
The first command appears one cycle after the start pulse. Each following command appears one cycle after the rspDone that finishes the previous one; the exception is the root-key save, which comes two cycles after it because the scratch write sits between. The doneOut pulse, for both error and success, comes one cycle after the deciding rspDone. The bench drives every input at the falling edge and checks at the falling edge in exactly those cycles, never by polling. While a command is held, the bench checks that cmdValid and every field stay steady for zero to two extra cycles. In the cycle after acceptance it checks that cmdValid has dropped.

// File: rtl/ctx_save_pkg.sv
package ctx_save_pkg;

  typedef enum logic [3:0] {
    PH_ROOTGEN,
    PH_RANDFILL,
    PH_RANDENC,
    PH_STICKY,
    PH_KEYTAB,
    PH_OIV,
    PH_UIV,
    PH_PATFILL,
    PH_PATENC,
    PH_ROOTSAVE
  } phase_e;

  localparam logic [1:0] OP_KEYGEN  = 2'd0;
  localparam logic [1:0] OP_RANDGEN = 2'd1;
  localparam logic [1:0] OP_PATLOAD = 2'd2;
  localparam logic [1:0] OP_SAVE    = 2'd3;

  localparam logic [1:0] SRC_STICKY = 2'd0;
  localparam logic [1:0] SRC_KEYTAB = 2'd1;
  localparam logic [1:0] SRC_MEM    = 2'd2;
  localparam logic [1:0] SRC_ROOT   = 2'd3;

  localparam logic [1:0] QD_OIV = 2'd2;
  localparam logic [1:0] QD_UIV = 2'd3;

  typedef struct packed {
    logic loadBase;
    logic clrIdx;
    logic incIdx;
  } dp_ctl_t;

endpackage

// File: rtl/ctx_save_dp.sv
module ctx_save_dp
  import ctx_save_pkg::*;
#(
  parameter int SLOTS     = 16,
  parameter int BLK_BYTES = 16,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dp_ctl_t                ctl,
  input  phase_e                 phase,
  input  logic [ADDR_W-1:0]      baseIn,
  output logic [1:0]             cmdOp,
  output logic [31:0]            cmdWord,
  output logic [ADDR_W-1:0]      cmdAddr,
  output logic [LEN_W-1:0]       cmdLen,
  output logic [BLK_BYTES*8-1:0] cmdData,
  output logic [ADDR_W-1:0]      scratchData,
  output logic                   lastIdx
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int IDX_W  = SLOT_W + 1;
  localparam logic [ADDR_W-1:0] BLK_A      = ADDR_W'(BLK_BYTES);
  localparam logic [ADDR_W-1:0] OFF_RAND   = '0;
  localparam logic [ADDR_W-1:0] OFF_STICKY = OFF_RAND + BLK_A;
  localparam logic [ADDR_W-1:0] OFF_KEYS   = OFF_STICKY + BLK_A;
  localparam logic [ADDR_W-1:0] OFF_OIV    = OFF_KEYS + ADDR_W'(2 * SLOTS * BLK_BYTES);
  localparam logic [ADDR_W-1:0] OFF_UIV    = OFF_OIV + ADDR_W'(SLOTS * BLK_BYTES);
  localparam logic [ADDR_W-1:0] OFF_PAT    = OFF_UIV + ADDR_W'(SLOTS * BLK_BYTES);

  logic [ADDR_W-1:0]      baseR;
  logic [IDX_W-1:0]       idx;
  logic [BLK_BYTES*8-1:0] patVal;
  logic [1:0]             src, quad;
  logic [SLOT_W-1:0]      slot;
  logic [ADDR_W-1:0]      off;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseR <= '0;
      idx   <= '0;
    end else begin
      if (ctl.loadBase) baseR <= baseIn;
      if (ctl.loadBase || ctl.clrIdx) idx <= '0;
      else if (ctl.incIdx)            idx <= idx + 1'b1;
    end
  end

  for (genvar gi = 0; gi < BLK_BYTES; gi++) begin : g_pat
    assign patVal[gi*8 +: 8] = 8'(gi);
  end

  always_comb begin
    cmdOp  = OP_SAVE;
    src    = SRC_MEM;
    quad   = '0;
    slot   = '0;
    off    = OFF_RAND;
    cmdLen = LEN_W'(BLK_BYTES);
    case (phase)
      PH_ROOTGEN:  cmdOp = OP_KEYGEN;
      PH_RANDFILL: cmdOp = OP_RANDGEN;
      PH_RANDENC:  off = OFF_RAND;
      PH_STICKY: begin src = SRC_STICKY; off = OFF_STICKY; end
      PH_KEYTAB: begin
        src  = SRC_KEYTAB;
        slot = idx[IDX_W-1:1];
        quad = {1'b0, idx[0]};
        off  = OFF_KEYS;
      end
      PH_OIV: begin src = SRC_KEYTAB; slot = idx[SLOT_W-1:0]; quad = QD_OIV; off = OFF_OIV; end
      PH_UIV: begin src = SRC_KEYTAB; slot = idx[SLOT_W-1:0]; quad = QD_UIV; off = OFF_UIV; end
      PH_PATFILL: begin cmdOp = OP_PATLOAD; off = OFF_PAT; end
      PH_PATENC:  off = OFF_PAT;
      PH_ROOTSAVE: begin src = SRC_ROOT; cmdLen = '0; end
      default: ;
    endcase
    cmdWord = '0;
    if (cmdOp == OP_SAVE) begin
      cmdWord[31:30]       = src;
      cmdWord[8 +: SLOT_W] = slot;
      cmdWord[1:0]         = quad;
    end
  end

  always_comb begin
    case (phase)
      PH_KEYTAB:      lastIdx = (idx == IDX_W'(2 * SLOTS - 1));
      PH_OIV, PH_UIV: lastIdx = (idx == IDX_W'(SLOTS - 1));
      default:        lastIdx = 1'b1;
    endcase
  end

  assign cmdAddr     = baseR + off + (ADDR_W'(idx) * BLK_A);
  assign cmdData     = (cmdOp == OP_PATLOAD) ? patVal : '0;
  assign scratchData = baseR;

endmodule

// File: rtl/ctx_save_ctrl.sv
module ctx_save_ctrl
  import ctx_save_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startIn,
  input  logic    cmdReady,
  input  logic    rspDone,
  input  logic    rspErr,
  input  logic    lastIdx,
  output phase_e  phase,
  output dp_ctl_t ctl,
  output logic    cmdValid,
  output logic    scratchWe,
  output logic    busyOut,
  output logic    doneOut,
  output logic    errOut
);
  typedef enum logic [2:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_SCRATCH, ST_DONE} state_e;

  state_e state;
  logic   errR;
  logic   rspOk;

  assign rspOk = (state == ST_WAIT) && rspDone && !rspErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= PH_ROOTGEN;
      errR  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (startIn) begin
          state <= ST_ISSUE;
          phase <= PH_ROOTGEN;
          errR  <= 1'b0;
        end
        ST_ISSUE: if (cmdReady) state <= ST_WAIT;
        ST_WAIT: if (rspDone) begin
          if (rspErr) begin
            errR  <= 1'b1;
            state <= ST_DONE;
          end else if (!lastIdx) begin
            state <= ST_ISSUE;
          end else if (phase == PH_PATENC) begin
            phase <= PH_ROOTSAVE;
            state <= ST_SCRATCH;
          end else if (phase == PH_ROOTSAVE) begin
            state <= ST_DONE;
          end else begin
            phase <= phase_e'(phase + 4'd1);
            state <= ST_ISSUE;
          end
        end
        ST_SCRATCH: state <= ST_ISSUE;
        ST_DONE:    state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.loadBase = (state == ST_IDLE) && startIn;
    ctl.clrIdx   = rspOk && lastIdx;
    ctl.incIdx   = rspOk && !lastIdx;
  end

  assign cmdValid  = (state == ST_ISSUE);
  assign scratchWe = (state == ST_SCRATCH);
  assign busyOut   = (state != ST_IDLE);
  assign doneOut   = (state == ST_DONE);
  assign errOut    = errR;

endmodule

// File: rtl/ctx_save_seq.sv
module ctx_save_seq
  import ctx_save_pkg::*;
#(
  parameter int SLOTS     = 16,
  parameter int BLK_BYTES = 16,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startIn,
  input  logic [ADDR_W-1:0]      baseAddrIn,
  output logic                   busyOut,
  output logic                   doneOut,
  output logic                   errOut,
  output logic                   cmdValid,
  input  logic                   cmdReady,
  output logic [1:0]             cmdOp,
  output logic [31:0]            cmdWord,
  output logic [ADDR_W-1:0]      cmdAddr,
  output logic [LEN_W-1:0]       cmdLen,
  output logic [BLK_BYTES*8-1:0] cmdData,
  input  logic                   rspDone,
  input  logic                   rspErr,
  output logic                   scratchWe,
  output logic [ADDR_W-1:0]      scratchData
);
  phase_e  phase;
  dp_ctl_t ctl;
  logic    lastIdx;

  ctx_save_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .cmdReady(cmdReady),
    .rspDone(rspDone), .rspErr(rspErr), .lastIdx(lastIdx), .phase(phase),
    .ctl(ctl), .cmdValid(cmdValid), .scratchWe(scratchWe), .busyOut(busyOut),
    .doneOut(doneOut), .errOut(errOut)
  );

  ctx_save_dp #(
    .SLOTS(SLOTS), .BLK_BYTES(BLK_BYTES), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .phase(phase), .baseIn(baseAddrIn),
    .cmdOp(cmdOp), .cmdWord(cmdWord), .cmdAddr(cmdAddr), .cmdLen(cmdLen),
    .cmdData(cmdData), .scratchData(scratchData), .lastIdx(lastIdx)
  );

endmodule

// File: rtl/ctx_save_sva.sv
module ctx_save_sva #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              startIn,
  input logic [ADDR_W-1:0] baseAddrIn,
  input logic              busyOut,
  input logic              doneOut,
  input logic              errOut,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [1:0]        cmdOp,
  input logic [31:0]       cmdWord,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [LEN_W-1:0]  cmdLen,
  input logic              rspDone,
  input logic              rspErr,
  input logic              scratchWe,
  input logic [ADDR_W-1:0] scratchData
);
  logic              pending;
  logic [ADDR_W-1:0] baseSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending  <= 1'b0;
      baseSeen <= '0;
    end else begin
      if (cmdValid && cmdReady) pending <= 1'b1;
      else if (rspDone)         pending <= 1'b0;
      if (!busyOut && startIn)  baseSeen <= baseAddrIn;
    end
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdOp) && $stable(cmdWord)
                              && $stable(cmdAddr) && $stable(cmdLen));

  a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> !cmdValid);

  a_r11_abort: assert property (@(posedge clk) disable iff (!rstN)
    pending && rspDone && rspErr |=> doneOut && errOut && !cmdValid && !scratchWe);

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut && !busyOut);

  a_r8_scratch_base: assert property (@(posedge clk) disable iff (!rstN)
    scratchWe |-> scratchData == baseSeen && !cmdValid);

  a_r9_root_len: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdOp == 2'd3 && cmdWord[31:30] == 2'd3 |-> cmdLen == '0);

  a_r13_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    busyOut && startIn |=> $stable(scratchData));

endmodule

bind ctx_save_seq ctx_save_sva #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_sva (
  .clk(clk), .rstN(rstN), .startIn(startIn), .baseAddrIn(baseAddrIn),
  .busyOut(busyOut), .doneOut(doneOut), .errOut(errOut), .cmdValid(cmdValid),
  .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdWord(cmdWord), .cmdAddr(cmdAddr),
  .cmdLen(cmdLen), .rspDone(rspDone), .rspErr(rspErr), .scratchWe(scratchWe),
  .scratchData(scratchData)
);

// File: tb/ctx_save_seq_bench.sv
`timescale 1ns/1ps
module ctx_save_seq_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startIn = 1'b0;
  logic [31:0]  baseAddrIn = '0;
  logic         busyOut, doneOut, errOut, cmdValid, scratchWe;
  logic         cmdReady = 1'b0;
  logic [1:0]   cmdOp;
  logic [31:0]  cmdWord, cmdAddr, scratchData;
  logic [15:0]  cmdLen;
  logic [127:0] cmdData;
  logic         rspDone = 1'b0;
  logic         rspErr = 1'b0;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  ctx_save_seq u_ctx_save_seq (
    .clk(clk), .rstN(rstN), .startIn(startIn), .baseAddrIn(baseAddrIn),
    .busyOut(busyOut), .doneOut(doneOut), .errOut(errOut), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdWord(cmdWord), .cmdAddr(cmdAddr),
    .cmdLen(cmdLen), .cmdData(cmdData), .rspDone(rspDone), .rspErr(rspErr),
    .scratchWe(scratchWe), .scratchData(scratchData)
  );

  // fields: [31:30] op, [29:28] src, [27:26] quad, [25] key loop,
  // [24] slot loop, [23] zero length, [22:16] count, [15:0] offset
  localparam logic [31:0] PH_TAB [10] = '{
    {2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 7'd1,  16'd0},
    {2'd1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 7'd1,  16'd0},
    {2'd3, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 7'd1,  16'd0},
    {2'd3, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 7'd1,  16'd16},
    {2'd3, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 7'd32, 16'd32},
    {2'd3, 2'd1, 2'd2, 1'b0, 1'b1, 1'b0, 7'd16, 16'd544},
    {2'd3, 2'd1, 2'd3, 1'b0, 1'b1, 1'b0, 7'd16, 16'd800},
    {2'd2, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 7'd1,  16'd1056},
    {2'd3, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 7'd1,  16'd1056},
    {2'd3, 2'd3, 2'd0, 1'b0, 1'b0, 1'b1, 7'd1,  16'd0}
  };

  localparam logic [127:0] PATTERN = 128'h0F0E0D0C0B0A09080706050403020100;

  function automatic string tagOf(input int p);
    case (p)
      3:       return "R4";
      4:       return "R5";
      5, 6:    return "R6";
      7, 8:    return "R7";
      9:       return "R9";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic serve(input int p, input int k, input logic [31:0] base,
                       input int delay, input bit inj, input bit poke);
    logic [31:0] e = PH_TAB[p];
    logic [1:0]  quad;
    logic [3:0]  slot;
    logic [31:0] word, addr;
    logic [15:0] len;
    logic [85:0] expV, actV;
    quad = e[27:26];
    slot = 4'd0;
    if (e[25]) begin slot = 4'(k / 2); quad = 2'(k % 2); end
    if (e[24]) slot = 4'(k);
    word = (e[31:30] == 2'd3) ? {e[29:28], 18'd0, slot, 6'd0, quad} : 32'd0;
    addr = base + 32'(e[15:0]) + 32'(k * 16);
    len  = e[23] ? 16'd0 : 16'd16;
    expV = {1'b1, e[31:30], word, addr, len, 3'd0};
    actV = {cmdValid, cmdOp, cmdWord, cmdAddr, cmdLen, 3'd0};
    chk(actV == expV, tagOf(p), $sformatf("cmd p%0d k%0d", p, k), 128'(actV), 128'(expV));
    if (p == 7) chk(cmdData == PATTERN, "R7", "pattern data", cmdData, PATTERN);
    for (int d = 0; d < delay; d++) begin
      if (poke && d == 0) begin startIn = 1'b1; baseAddrIn = 32'hDEAD_0000; end
      @(negedge clk);
      startIn = 1'b0;
      actV = {cmdValid, cmdOp, cmdWord, cmdAddr, cmdLen, 3'd0};
      chk(actV == expV, poke ? "R13" : "R10", "held cmd", 128'(actV), 128'(expV));
    end
    cmdReady = 1'b1;
    @(negedge clk);
    cmdReady = 1'b0;
    chk(!cmdValid, "R10", "valid after accept", 128'(cmdValid), 128'(0));
    rspDone = 1'b1;
    rspErr  = inj;
    @(negedge clk);
    rspDone = 1'b0;
    rspErr  = 1'b0;
  endtask

  task automatic runSeq(input logic [31:0] base, input int errP, input int errK);
    bit bad;
    baseAddrIn = base;
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    baseAddrIn = ~base;
    chk(busyOut, "R2", "busy after start", 128'(busyOut), 128'(1));
    for (int p = 0; p < 10; p++) begin
      for (int k = 0; k < int'(PH_TAB[p][22:16]); k++) begin
        bit inj = (p == errP) && (k == errK);
        if (p == 9) begin
          chk(scratchWe && !cmdValid && scratchData == base, "R8", "scratch write",
              128'({scratchWe, cmdValid, scratchData}), 128'({2'b10, base}));
          @(negedge clk);
          chk(!scratchWe, "R8", "scratch single", 128'(scratchWe), 128'(0));
        end
        serve(p, k, base, k % 3, inj, (p == 4) && (k == 4));
        if (inj) begin
          chk(doneOut && errOut, "R11", "error done",
              128'({doneOut, errOut}), 128'(2'b11));
          bad = 1'b0;
          for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (cmdValid || scratchWe || doneOut) bad = 1'b1;
          end
          chk(!bad, "R11", "quiet after error", 128'(bad), 128'(0));
          chk(errOut && !busyOut, "R12", "status held",
              128'({errOut, busyOut}), 128'(2'b10));
          return;
        end
      end
    end
    chk(doneOut && !errOut && busyOut, "R12", "ok done",
        128'({doneOut, errOut, busyOut}), 128'(3'b101));
    @(negedge clk);
    chk(!doneOut && !busyOut && !errOut, "R12", "done single",
        128'({doneOut, busyOut, errOut}), 128'(0));
  endtask

  task automatic runAll();
    repeat (2) @(negedge clk);
    chk(!busyOut && !cmdValid && !doneOut && !scratchWe, "R1", "in reset",
        128'({busyOut, cmdValid, doneOut, scratchWe}), 128'(0));
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busyOut && !cmdValid && !doneOut && !scratchWe, "R1", "after reset",
        128'({busyOut, cmdValid, doneOut, scratchWe}), 128'(0));
    runSeq(32'h1000_0000, 99, 0);
    repeat (3) @(negedge clk);
    runSeq(32'h2000_0040, 4, 5);
    runSeq(32'hFFFF_FC00, 0, 0);
    runSeq(32'h0000_0100, 6, 15);
    runSeq(32'h0000_0100, 99, 0);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (20000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL R12 watchdog: actual=hung expected=finished");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule